// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block runs erase and program jobs on one sector of a byte-wide parallel NOR flash. The host picks the job, presents a sector base address and pulses `start`. The block then drives the flash bus on its own. It sends the standard unlock-and-command write cycles and waits for the internal operation to finish by polling for a toggling status byte. After that it issues a reset command and reads the whole sector back to check the result. When the job ends, the block pulses `done` and holds a result code until the next job starts.

An erase sends one six-write command and waits for one completion. A program job handles each byte in turn: it sends a four-write command with the byte taken from the source, then waits for that byte to complete. The program data source is a plain indexed lookup with no handshake and no back-pressure. The block places a byte offset on `src_off`, and the source must return the matching byte on `src_data` in the same cycle. The data source has no valid/ready pair, so nothing can stall the block from that side. The flash side follows fixed timing, and the host side uses plain level and pulse signals.

Top module: `pflash_sequencer`

## Requirements
- R1: An erase writes exactly these six cycles in this order, as address←data with base B: B+0x555←0xAA, B+0x2AA←0x55, B+0x555←0x80, B+0x555←0xAA, B+0x2AA←0x55, B←0x30.
- R2: A program job handles byte offsets 0 to SECT_BYTES-1 in ascending order. For each offset k it writes B+0x555←0xAA, B+0x2AA←0x55, B+0x555←0xA0 and then B+k←`src_data` (taken while `src_off`=k), and it waits for completion before moving to the next offset.
- R3: Completion is a pair of consecutive reads of address B that return identical bytes. A pair that differs counts as one failed poll, and the block starts a new pair.
- R4: When POLL_LIMIT failed polls in a row occur, the job ends at once with code 1 (erase) or 3 (program). No reset command and no verify follow. A match on poll number POLL_LIMIT still counts as success.
- R5: After the erase completes, and after the last byte is programmed, the block writes B←0xF0 once and then starts the read-back.
- R6: The erase read-back reads B+0 upward. The first byte that is not 0xFF ends the job with code 2.
- R7: The program read-back reads B+0 upward and compares each byte with `src_data` for that offset. The first mismatch ends the job with code 4.
- R8: Every write holds `fl_we` high for exactly one cycle, never overlaps with `fl_oe`, and keeps address and data stable afterwards. At least SETTLE_CYC idle bus cycles follow each write. Every read holds `fl_oe` high for exactly two cycles, and `fl_din` is sampled at the end of the second cycle.
- R9: `busy` rises on an accepted `start`. `done` is a one-cycle pulse that coincides with `busy` falling. `err_code` is 0 on success. A `start` while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `fl_we` and `fl_oe` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (ignored while busy) |
| op_prog | input | 1 | Job select: 0 erase, 1 program |
| sect_base | input | ADDR_W | Sector base address B, sampled at start |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err_code | output | 3 | 0 ok, 1 erase timeout, 2 erase verify, 3 program timeout, 4 program verify |
| src_off | output | $clog2(SECT_BYTES) | Byte offset requested from the data source |
| src_data | input | 8 | Source byte for `src_off`, same cycle |
| fl_addr | output | ADDR_W | Flash address |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data |
| fl_we | output | 1 | Flash write strobe, active high |
| fl_oe | output | 1 | Flash read strobe, active high |

## Verification
The bench builds the block with ADDR_W=12, SECT_BYTES=16, SETTLE_CYC=3 and POLL_LIMIT=8. The small poll limit makes both sides of the timeout boundary reachable in a few hundred cycles: a completion on exactly the eighth poll and a failure after eight failed polls. The 16-byte sector lets every program job run to the end, including the full read-back. The bench can then plant a bad byte in the middle of the sector for either kind of verify.

// File: rtl/pfseq_pkg.sv
package pfseq_pkg;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_ERA_TMO  = 3'd1,
    RES_ERA_VFY  = 3'd2,
    RES_PRG_TMO  = 3'd3,
    RES_PRG_VFY  = 3'd4
  } pfseq_res_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CMD,
    SQ_POLL_A,
    SQ_POLL_B,
    SQ_RST,
    SQ_VFY,
    SQ_FIN
  } pfseq_st_e;

  typedef enum logic [2:0] {
    BU_IDLE,
    BU_WSTB,
    BU_WSET,
    BU_RSTB,
    BU_RSMP
  } pfseq_bus_e;

  localparam logic [10:0] OFF_U1   = 11'h555;
  localparam logic [10:0] OFF_U2   = 11'h2AA;
  localparam logic [7:0]  DAT_U1   = 8'hAA;
  localparam logic [7:0]  DAT_U2   = 8'h55;
  localparam logic [7:0]  DAT_ERS  = 8'h80;
  localparam logic [7:0]  DAT_SECT = 8'h30;
  localparam logic [7:0]  DAT_PRG  = 8'hA0;
  localparam logic [7:0]  DAT_RST  = 8'hF0;
  localparam logic [7:0]  BLANK    = 8'hFF;

endpackage

// File: rtl/pfseq_cmdrom.sv
module pfseq_cmdrom
  import pfseq_pkg::*;
(
  input  logic        op_prog,
  input  logic [2:0]  step,
  input  logic [7:0]  prog_byte,
  output logic [10:0] off,
  output logic [7:0]  data,
  output logic        use_idx,
  output logic        last
);

  always_comb begin
    off     = 11'h000;
    data    = DAT_RST;
    use_idx = 1'b0;
    last    = 1'b0;
    if (op_prog) begin
      case (step)
        3'd0:    begin off = OFF_U1; data = DAT_U1; end
        3'd1:    begin off = OFF_U2; data = DAT_U2; end
        3'd2:    begin off = OFF_U1; data = DAT_PRG; end
        default: begin data = prog_byte; use_idx = 1'b1; last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0:    begin off = OFF_U1; data = DAT_U1; end
        3'd1:    begin off = OFF_U2; data = DAT_U2; end
        3'd2:    begin off = OFF_U1; data = DAT_ERS; end
        3'd3:    begin off = OFF_U1; data = DAT_U1; end
        3'd4:    begin off = OFF_U2; data = DAT_U2; end
        default: begin data = DAT_SECT; last = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/pfseq_buseng.sv
module pfseq_buseng
  import pfseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SETTLE_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              ack,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dout,
  input  logic [7:0]        fl_din,
  output logic              fl_we,
  output logic              fl_oe
);

  localparam int SW = $clog2(SETTLE_CYC + 2);
  localparam logic [SW-1:0] SET_LAST = SW'(SETTLE_CYC - 1);

  pfseq_bus_e      bst;
  logic [SW-1:0]   set_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst     <= BU_IDLE;
      set_cnt <= '0;
      fl_addr <= '0;
      fl_dout <= '0;
      rdata   <= '0;
      ack     <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (bst)
        BU_IDLE: begin
          if (wr_go) begin
            fl_addr <= addr;
            fl_dout <= wdata;
            bst     <= BU_WSTB;
          end else if (rd_go) begin
            fl_addr <= addr;
            bst     <= BU_RSTB;
          end
        end
        BU_WSTB: begin
          set_cnt <= '0;
          bst     <= BU_WSET;
        end
        BU_WSET: begin
          if (set_cnt == SET_LAST) begin
            ack <= 1'b1;
            bst <= BU_IDLE;
          end else begin
            set_cnt <= set_cnt + 1'b1;
          end
        end
        BU_RSTB: bst <= BU_RSMP;
        BU_RSMP: begin
          rdata <= fl_din;
          ack   <= 1'b1;
          bst   <= BU_IDLE;
        end
        default: bst <= BU_IDLE;
      endcase
    end
  end

  assign fl_we = (bst == BU_WSTB);
  assign fl_oe = (bst == BU_RSTB) || (bst == BU_RSMP);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_oe));
  assert_we_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> !fl_we && !fl_oe);
  assert_we_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> $stable(fl_addr) && $stable(fl_dout));
  assert_oe_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_oe) |=> fl_oe && $stable(fl_addr));

endmodule

// File: rtl/pfseq_pollcnt.sv
module pfseq_pollcnt #(
  parameter int POLL_LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic expired
);

  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = miss && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (miss && !expired) cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST);

endmodule

// File: rtl/pflash_sequencer.sv
module pflash_sequencer
  import pfseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SECT_BYTES = 256,
  parameter int SETTLE_CYC = 50,
  parameter int POLL_LIMIT = 1000000,
  localparam int IDX_W     = $clog2(SECT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_prog,
  input  logic [ADDR_W-1:0] sect_base,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  output logic [IDX_W-1:0]  src_off,
  input  logic [7:0]        src_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dout,
  input  logic [7:0]        fl_din,
  output logic              fl_we,
  output logic              fl_oe
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SECT_BYTES - 1);

  pfseq_st_e         st;
  pfseq_res_e        res_q;
  logic              op_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [2:0]        step_q;
  logic              go_q;
  logic [7:0]        first_q;

  logic [10:0]       c_off;
  logic [7:0]        c_data;
  logic              c_use_idx;
  logic              c_last;

  logic              eng_ack;
  logic [7:0]        eng_rdata;
  logic [ADDR_W-1:0] eng_addr;
  logic [7:0]        eng_wdata;
  logic              wr_go;
  logic              rd_go;

  logic              poll_clr;
  logic              poll_miss;
  logic              poll_exp;
  logic [7:0]        exp_byte;

  pfseq_cmdrom u_rom (
    .op_prog   (op_q),
    .step      (step_q),
    .prog_byte (src_data),
    .off       (c_off),
    .data      (c_data),
    .use_idx   (c_use_idx),
    .last      (c_last)
  );

  always_comb begin
    eng_addr  = base_q;
    eng_wdata = DAT_RST;
    case (st)
      SQ_CMD: begin
        eng_addr  = base_q + (c_use_idx ? ADDR_W'(idx_q) : ADDR_W'(c_off));
        eng_wdata = c_data;
      end
      SQ_VFY:  eng_addr = base_q + ADDR_W'(idx_q);
      default: eng_addr = base_q;
    endcase
  end

  assign wr_go = go_q && ((st == SQ_CMD) || (st == SQ_RST));
  assign rd_go = go_q && ((st == SQ_POLL_A) || (st == SQ_POLL_B) || (st == SQ_VFY));

  pfseq_buseng #(
    .ADDR_W     (ADDR_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .addr    (eng_addr),
    .wdata   (eng_wdata),
    .ack     (eng_ack),
    .rdata   (eng_rdata),
    .fl_addr (fl_addr),
    .fl_dout (fl_dout),
    .fl_din  (fl_din),
    .fl_we   (fl_we),
    .fl_oe   (fl_oe)
  );

  assign poll_clr  = (st == SQ_CMD);
  assign poll_miss = (st == SQ_POLL_B) && eng_ack && (eng_rdata != first_q);

  pfseq_pollcnt #(
    .POLL_LIMIT (POLL_LIMIT)
  ) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (poll_clr),
    .miss    (poll_miss),
    .expired (poll_exp)
  );

  assign exp_byte = op_q ? src_data : BLANK;
  assign src_off  = idx_q;
  assign err_code = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      res_q   <= RES_OK;
      op_q    <= 1'b0;
      base_q  <= '0;
      idx_q   <= '0;
      step_q  <= '0;
      go_q    <= 1'b0;
      first_q <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      done <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            op_q   <= op_prog;
            base_q <= sect_base;
            idx_q  <= '0;
            step_q <= '0;
            res_q  <= RES_OK;
            busy   <= 1'b1;
            go_q   <= 1'b1;
            st     <= SQ_CMD;
          end
        end
        SQ_CMD: begin
          if (eng_ack) begin
            go_q <= 1'b1;
            if (c_last) begin
              st <= SQ_POLL_A;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        SQ_POLL_A: begin
          if (eng_ack) begin
            first_q <= eng_rdata;
            go_q    <= 1'b1;
            st      <= SQ_POLL_B;
          end
        end
        SQ_POLL_B: begin
          if (eng_ack) begin
            if (eng_rdata == first_q) begin
              go_q <= 1'b1;
              if (!op_q || (idx_q == IDX_LAST)) begin
                idx_q <= '0;
                st    <= SQ_RST;
              end else begin
                idx_q  <= idx_q + 1'b1;
                step_q <= '0;
                st     <= SQ_CMD;
              end
            end else if (poll_exp) begin
              res_q <= op_q ? RES_PRG_TMO : RES_ERA_TMO;
              st    <= SQ_FIN;
            end else begin
              go_q <= 1'b1;
              st   <= SQ_POLL_A;
            end
          end
        end
        SQ_RST: begin
          if (eng_ack) begin
            idx_q <= '0;
            go_q  <= 1'b1;
            st    <= SQ_VFY;
          end
        end
        SQ_VFY: begin
          if (eng_ack) begin
            if (eng_rdata != exp_byte) begin
              res_q <= op_q ? RES_PRG_VFY : RES_ERA_VFY;
              st    <= SQ_FIN;
            end else if (idx_q == IDX_LAST) begin
              st <= SQ_FIN;
            end else begin
              idx_q <= idx_q + 1'b1;
              go_q  <= 1'b1;
            end
          end
        end
        SQ_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code <= 3'd4));
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_tmo_no_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_FIN) && ((res_q == RES_ERA_TMO) || (res_q == RES_PRG_TMO))
      |-> !fl_we);

endmodule

// File: tb/pflash_sequencer_bench.sv
module pflash_sequencer_bench;

  localparam int AW     = 12;
  localparam int NB     = 16;
  localparam int SETTLE = 3;
  localparam int LIMIT  = 8;
  localparam int IW     = $clog2(NB);
  localparam logic [AW-1:0] BASE = 12'h800;

  // vector: [23] op, [22:21] fault (0 none,1 erase bad,2 program bad),
  // [20:16] busy reads (31 = never settles), [15:8] seed, [2:0] expected code
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 2'd0, 5'd2,  8'h00, 5'd0, 3'd0},
    {1'b1, 2'd0, 5'd2,  8'h11, 5'd0, 3'd0},
    {1'b0, 2'd1, 5'd1,  8'h00, 5'd0, 3'd2},
    {1'b1, 2'd2, 5'd0,  8'h5A, 5'd0, 3'd4},
    {1'b0, 2'd0, 5'd31, 8'h00, 5'd0, 3'd1},
    {1'b1, 2'd0, 5'd31, 8'h3C, 5'd0, 3'd3},
    {1'b0, 2'd0, 5'd14, 8'h00, 5'd0, 3'd0},
    {1'b0, 2'd0, 5'd16, 8'h00, 5'd0, 3'd1},
    {1'b1, 2'd0, 5'd14, 8'hC3, 5'd0, 3'd0}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           op_prog = 1'b0;
  logic [AW-1:0]  sect_base = BASE;
  logic           busy, done;
  logic [2:0]     err_code;
  logic [IW-1:0]  src_off;
  logic [7:0]     src_data;
  logic [AW-1:0]  fl_addr;
  logic [7:0]     fl_dout;
  logic [7:0]     fl_din = 8'h00;
  logic           fl_we, fl_oe;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pflash_sequencer #(
    .ADDR_W (AW), .SECT_BYTES (NB), .SETTLE_CYC (SETTLE), .POLL_LIMIT (LIMIT)
  ) u_pflash_sequencer (
    .clk (clk), .rst_n (rst_n), .start (start), .op_prog (op_prog),
    .sect_base (sect_base), .busy (busy), .done (done), .err_code (err_code),
    .src_off (src_off), .src_data (src_data), .fl_addr (fl_addr),
    .fl_dout (fl_dout), .fl_din (fl_din), .fl_we (fl_we), .fl_oe (fl_oe)
  );

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 37 + 5) ^ s;
  endfunction

  logic [7:0] seed = 8'h00;
  assign src_data = pat(int'(src_off), seed);

  // behavioural flash
  logic [7:0]    mem [NB];
  logic [AW-1:0] log_a [1024];
  logic [7:0]    log_d [1024];
  int            log_n = 0;
  int            cfg_busy = 0;
  int            cfg_fault = 0;
  int            busy_left = 0;
  logic          armed = 1'b0;
  logic          tog = 1'b0;
  logic          oe_q = 1'b0;

  always @(posedge clk) begin
    oe_q <= fl_oe;
    if (fl_we) begin
      log_a[log_n] <= fl_addr;
      log_d[log_n] <= fl_dout;
      log_n <= log_n + 1;
      if (armed) begin
        armed <= 1'b0;
        busy_left <= cfg_busy;
        if (fl_addr >= BASE && fl_addr < BASE + NB)
          mem[int'(fl_addr - BASE)] <= (cfg_fault == 2 && fl_addr == BASE + 9)
                                       ? (fl_dout ^ 8'h01) : fl_dout;
      end else if (fl_dout == 8'hA0 && fl_addr == BASE + 12'h555) begin
        armed <= 1'b1;
      end else if (fl_dout == 8'h30 && fl_addr == BASE) begin
        busy_left <= cfg_busy;
        for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
        if (cfg_fault == 1) mem[9] <= 8'h7F;
      end
    end
    if (fl_oe && !oe_q) begin
      if (cfg_busy == 31 || busy_left > 0) begin
        tog <= ~tog;
        fl_din <= tog ? 8'h40 : 8'h00;
        if (cfg_busy != 31) busy_left <= busy_left - 1;
      end else if (fl_addr >= BASE && fl_addr < BASE + NB) begin
        fl_din <= mem[int'(fl_addr - BASE)];
      end else begin
        fl_din <= 8'h00;
      end
    end
  end

  // bus timing monitor (R8)
  int cyc = 0, last_we = -1, min_gap = 1000000, we_run = 0, we_run_max = 0;
  int oe_run = 0, oe_min = 1000, oe_max = 0, overlap = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fl_we && fl_oe) overlap <= overlap + 1;
    if (fl_we) begin
      we_run <= we_run + 1;
      if (we_run + 1 > we_run_max) we_run_max <= we_run + 1;
      if (we_run == 0 && last_we >= 0 && cyc - last_we < min_gap) min_gap <= cyc - last_we;
      if (we_run == 0) last_we <= cyc;
    end else we_run <= 0;
    if (fl_oe) oe_run <= oe_run + 1;
    else if (oe_run != 0) begin
      if (oe_run < oe_min) oe_min <= oe_run;
      if (oe_run > oe_max) oe_max <= oe_run;
      oe_run <= 0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int dones = 0;
  task automatic run_op(input logic op, output logic [2:0] code);
    @(negedge clk);
    op_prog = op;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    code = 3'd7;
    for (int n = 0; n < 20000; n++) begin
      if (done) begin
        code = err_code;
        dones++;
        break;
      end
      @(negedge clk);
    end
    if (code == 3'd7) chk(1'b0, "R9 job hung", 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] code;
    int l0, nw;
    logic ok;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !fl_we && !fl_oe, "R10 strobes/status", int'({busy, done, fl_we, fl_oe}), 0);
    chk(err_code == 3'd0, "R10 code", int'(err_code), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && err_code == 3'd0, "R10 after release", int'(busy), 0);

    for (int v = 0; v < NV; v++) begin
      logic        vop;
      logic [2:0]  vexp;
      string       tag;
      vop       = VEC[v][23];
      cfg_fault = int'(VEC[v][22:21]);
      cfg_busy  = int'(VEC[v][20:16]);
      seed      = VEC[v][15:8];
      vexp      = VEC[v][2:0];
      case (vexp)
        3'd0:    tag = "R3 ok";
        3'd2:    tag = "R6 erase verify";
        3'd4:    tag = "R7 program verify";
        default: tag = "R4 timeout";
      endcase
      l0 = log_n;
      run_op(vop, code);
      nw = log_n - l0;
      chk(code == vexp, tag, int'(code), int'(vexp));
      if (vexp == 3'd1 || vexp == 3'd3) begin
        chk(nw == (vop ? 4 : 6), "R4 no reset after timeout", nw, vop ? 4 : 6);
        chk(log_d[log_n-1] != 8'hF0, "R4 last write", int'(log_d[log_n-1]), 0);
      end else begin
        chk(nw == (vop ? 4 * NB + 1 : 7), "R5 write count", nw, vop ? 4 * NB + 1 : 7);
        chk(log_a[log_n-1] == BASE && log_d[log_n-1] == 8'hF0, "R5 reset command",
            int'(log_d[log_n-1]), 8'hF0);
      end
      if (vexp == 3'd0 && !vop) begin
        ok = 1'b1;
        for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) ok = 1'b0;
        chk(ok, "R6 sector blank", int'(ok), 1);
      end
      if (vexp == 3'd0 && vop) begin
        ok = 1'b1;
        for (int i = 0; i < NB; i++) if (mem[i] != pat(i, seed)) ok = 1'b0;
        chk(ok, "R2 programmed content", int'(ok), 1);
      end
      if (v == 0) begin
        chk(log_a[l0] == BASE + 12'h555 && log_d[l0] == 8'hAA, "R1 cycle 1", int'(log_d[l0]), 8'hAA);
        chk(log_a[l0+1] == BASE + 12'h2AA && log_d[l0+1] == 8'h55, "R1 cycle 2", int'(log_d[l0+1]), 8'h55);
        chk(log_a[l0+2] == BASE + 12'h555 && log_d[l0+2] == 8'h80, "R1 cycle 3", int'(log_d[l0+2]), 8'h80);
        chk(log_a[l0+3] == BASE + 12'h555 && log_d[l0+3] == 8'hAA, "R1 cycle 4", int'(log_d[l0+3]), 8'hAA);
        chk(log_a[l0+4] == BASE + 12'h2AA && log_d[l0+4] == 8'h55, "R1 cycle 5", int'(log_d[l0+4]), 8'h55);
        chk(log_a[l0+5] == BASE && log_d[l0+5] == 8'h30, "R1 cycle 6", int'(log_d[l0+5]), 8'h30);
      end
      if (v == 1) begin
        chk(log_a[l0+2] == BASE + 12'h555 && log_d[l0+2] == 8'hA0, "R2 program command",
            int'(log_d[l0+2]), 8'hA0);
        chk(log_a[l0+7] == BASE + 1 && log_d[l0+7] == pat(1, seed), "R2 second byte",
            int'(log_d[l0+7]), int'(pat(1, seed)));
        chk(log_a[l0+63] == BASE + NB - 1 && log_d[l0+63] == pat(NB - 1, seed), "R2 last byte",
            int'(log_a[l0+63]), int'(BASE) + NB - 1);
      end
    end

    // R9: start while busy is ignored
    cfg_fault = 0;
    cfg_busy  = 2;
    l0 = log_n;
    dones = 0;
    @(negedge clk);
    op_prog = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9 busy after start", int'(busy), 1);
    repeat (10) @(negedge clk);
    op_prog = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      if (done) begin
        dones++;
        break;
      end
      @(negedge clk);
    end
    chk(err_code == 3'd0, "R9 success code", int'(err_code), 0);
    repeat (60) @(negedge clk);
    chk(log_n - l0 == 7, "R9 second start ignored", log_n - l0, 7);
    chk(!busy && dones == 1, "R9 single done", dones, 1);

    // R8 bus timing
    chk(overlap == 0, "R8 strobe overlap", overlap, 0);
    chk(we_run_max == 1, "R8 write strobe width", we_run_max, 1);
    chk(min_gap >= SETTLE + 1, "R8 settle gap", min_gap, SETTLE + 1);
    chk(oe_min == 2 && oe_max == 2, "R8 read strobe width", oe_max, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule